// File: doc/BRIEF.md
# Boot ROM Region Chip-Select Decoder

This block watches memory requests from a host interface and decides whether each one falls inside the boot ROM address space. When a request hits, the block takes ownership of the cycle and raises a claim flag. It then starts an ISA-style memory cycle with the ROM chip select and the matching strobes driven low. The cycle holds until the bus side returns a one-cycle acknowledge. At that point every strobe and the claim flag are released on the same clock edge.

After reset the block decodes two windows. The first is the 64 KB that ends at the 1 MB boundary (000F0000h–000FFFFFh). The second is the top 256 KB of the 32-bit space (FFFC0000h–FFFFFFFFh). Each window has its own widening bit: the low window can grow to 128 KB (000E0000h–000FFFFFh) and the high window to 16 MB (FF000000h–FFFFFFFFh).

Reads always reach the ROM. A write to a ROM address is still claimed and still drives the write strobes. The chip select, however, stays inactive unless the flash-write enable bit is set. The ROM data width comes from a strap latched during reset, and a configuration override can replace it.

The cycle controller has four named states:

| State | Meaning |
|---|---|
| `ST_IDLE` | No cycle is in progress. |
| `ST_READ` | A ROM read is in progress. |
| `ST_WRITE` | A flash write is in progress, with the chip select low. |
| `ST_WRITE_MUTED` | A write is in progress with the chip select held high. |

Its transitions are:

- **accept-read**: `ST_IDLE`→`ST_READ`
- **accept-write**: `ST_IDLE`→`ST_WRITE`
- **accept-muted-write**: `ST_IDLE`→`ST_WRITE_MUTED`
- **release**: any active state→`ST_IDLE` when `bus_ack` is sampled high
- **wait**: an active state stays where it is while `bus_ack` is low

Top module: `rom_cs_decoder`

## Requirements
- R1: With `cfg_lo_wide`=0, addresses 000F0000h through 000FFFFFh are claimed, and 000EFFFFh and 00100000h are not.
- R2: With `cfg_hi_wide`=0, addresses FFFC0000h through FFFFFFFFh are claimed, and FFFBFFFFh is not.
- R3: With `cfg_lo_wide`=1, the low window covers 000E0000h through 000FFFFFh, and 000DFFFFh is not claimed.
- R4: With `cfg_hi_wide`=1, the high window covers FF000000h through FFFFFFFFh, and FEFFFFFFh is not claimed.
- R5: A read request that hits (`req_valid`=1 and `req_write`=0, sampled in idle) produces the following at the next clock edge: `claim`=1, `rom_cs_n`=0 and `memr_n`=0, with `memw_n`=1 and `wr_n`=1.
- R6: A write that hits while `cfg_wr_en`=0 produces `claim`=1, `memw_n`=0 and `wr_n`=0. In this case `rom_cs_n`=1 and `memr_n`=1.
- R7: A write that hits while `cfg_wr_en`=1 produces `claim`=1 with `rom_cs_n`, `memw_n` and `wr_n` all 0.
- R8: A request outside every enabled window leaves `claim`=0 and all active-low strobes at 1.
- R9: An active cycle holds its outputs until `bus_ack` is sampled high. At that edge the claim and every strobe return to idle together.
- R10: A request presented while a cycle is active is ignored: the outputs do not change, and no new cycle starts after the release.
- R11: `width_strap` is latched while `rst_n` is low. Later strap changes have no effect. `rom_is16`=1 means a 16-bit ROM and 0 means an 8-bit ROM.
- R12: While `cfg_width_ovr`=1, `rom_is16` follows `cfg_width16`. When the override is cleared, the latched strap value returns.
- R13: During and right after reset, `claim`=0 and all strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the strap latch window |
| req_valid | input | 1 | Host memory request present this cycle |
| req_addr | input | 32 | Host byte address |
| req_write | input | 1 | 1 = write request, 0 = read request |
| bus_ack | input | 1 | Bus-side acknowledge that ends the active cycle |
| width_strap | input | 1 | Reset-time width strap (1 = 16-bit) |
| cfg_lo_wide | input | 1 | Widen the low window to 128 KB |
| cfg_hi_wide | input | 1 | Widen the high window to 16 MB |
| cfg_wr_en | input | 1 | Let writes reach the ROM chip select |
| cfg_width_ovr | input | 1 | Width override enable |
| cfg_width16 | input | 1 | Override width value (1 = 16-bit) |
| claim | output | 1 | Cycle claimed by the ROM decoder |
| rom_cs_n | output | 1 | ROM chip select, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| wr_n | output | 1 | Generic write strobe, active low |
| rom_is16 | output | 1 | Selected ROM data width |

## Verification
The assertions check on every cycle that the block behaves consistently. The chip select never appears without a claim, and the read and write strobes are never low together. A chip-selected write only starts when the write enable was set. A miss in idle leaves the outputs idle, and outputs stay frozen until the acknowledge and then release together. Without an override, the width never drifts. Only the bench scenarios can show the exact window edges under each widening setting. They also show the precise strobe pattern for each cycle type, the strap latching across two resets, and the override taking effect and clearing.

// File: rtl/rom_dec_pkg.sv
package rom_dec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_READ        = 2'd1,
        ST_WRITE       = 2'd2,
        ST_WRITE_MUTED = 2'd3
    } rom_cyc_e;

    typedef struct packed {
        logic claim;
        logic cs_n;
        logic memr_n;
        logic memw_n;
        logic wr_n;
    } rom_strb_t;

    localparam rom_strb_t STRB_IDLE = '{claim: 1'b0, cs_n: 1'b1, memr_n: 1'b1,
                                        memw_n: 1'b1, wr_n: 1'b1};

    function automatic rom_strb_t strobes_for(rom_cyc_e st);
        rom_strb_t s;
        s = STRB_IDLE;
        unique case (st)
            ST_IDLE: s = STRB_IDLE;
            ST_READ: begin
                s.claim  = 1'b1;
                s.cs_n   = 1'b0;
                s.memr_n = 1'b0;
            end
            ST_WRITE: begin
                s.claim  = 1'b1;
                s.cs_n   = 1'b0;
                s.memw_n = 1'b0;
                s.wr_n   = 1'b0;
            end
            ST_WRITE_MUTED: begin
                s.claim  = 1'b1;
                s.memw_n = 1'b0;
                s.wr_n   = 1'b0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rom_window_match.sv
module rom_window_match #(
    parameter int ADDR_W      = 32,
    parameter int END_LOG2    = 20,
    parameter int NARROW_LOG2 = 16,
    parameter int WIDE_LOG2   = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              widen,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] END_V    = ADDR_W'((65'd1 << END_LOG2) - 65'd1);
    localparam logic [ADDR_W-1:0] NARROW_M = ADDR_W'((65'd1 << NARROW_LOG2) - 65'd1);
    localparam logic [ADDR_W-1:0] WIDE_M   = ADDR_W'((65'd1 << WIDE_LOG2) - 65'd1);

    logic [ADDR_W-1:0] span_mask;

    always_comb begin
        span_mask = widen ? WIDE_M : NARROW_M;
        // Window ends at 2**END_LOG2-1; filling the span bits must land exactly there.
        hit = ((addr | span_mask) == END_V);
    end
endmodule

// File: rtl/rom_width_sel.sv
module rom_width_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic ovr_en,
    input  logic ovr_w16,
    output logic is16
);
    logic strap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap;
    end

    always_comb is16 = ovr_en ? ovr_w16 : strap_q;

    a_r11_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ovr_en && $past(!ovr_en)) |-> $stable(is16));
endmodule

// File: rtl/rom_cycle_fsm.sv
module rom_cycle_fsm
    import rom_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      req_write,
    input  logic      hit,
    input  logic      wr_en,
    input  logic      bus_ack,
    output rom_strb_t strb
);
    rom_cyc_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && hit) begin
                    if (!req_write)  state_d = ST_READ;
                    else if (wr_en)  state_d = ST_WRITE;
                    else             state_d = ST_WRITE_MUTED;
                end
            end
            ST_READ, ST_WRITE, ST_WRITE_MUTED: begin
                if (bus_ack) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs registered from the next state so all strobes change on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strb <= STRB_IDLE;
        else        strb <= strobes_for(state_d);
    end

    a_r5_cs_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.cs_n |-> strb.claim);
    a_r5_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!strb.memr_n && !strb.memw_n));
    a_r7_cs_write_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(strb.memw_n) && !strb.cs_n) |-> $past(wr_en));
    a_r6_write_muted: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(strb.memw_n) && !$past(wr_en)) |-> strb.cs_n);
    a_r8_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && !hit) |=> (strb == STRB_IDLE));
    a_r9_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && bus_ack) |=> (strb == STRB_IDLE));
    a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !bus_ack) |=> $stable(strb));
endmodule

// File: rtl/rom_cs_decoder.sv
module rom_cs_decoder
    import rom_dec_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LO_END     = 20,
    parameter int LO_NARROW  = 16,
    parameter int LO_WIDE    = 17,
    parameter int HI_NARROW  = 18,
    parameter int HI_WIDE    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              bus_ack,
    input  logic              width_strap,
    input  logic              cfg_lo_wide,
    input  logic              cfg_hi_wide,
    input  logic              cfg_wr_en,
    input  logic              cfg_width_ovr,
    input  logic              cfg_width16,
    output logic              claim,
    output logic              rom_cs_n,
    output logic              memr_n,
    output logic              memw_n,
    output logic              wr_n,
    output logic              rom_is16
);
    localparam int NWIN = 2;
    localparam int WIN_END    [NWIN] = '{LO_END, ADDR_W};
    localparam int WIN_NARROW [NWIN] = '{LO_NARROW, HI_NARROW};
    localparam int WIN_WIDE   [NWIN] = '{LO_WIDE, HI_WIDE};

    logic [NWIN-1:0] win_widen;
    logic [NWIN-1:0] win_hit;
    logic            any_hit;
    rom_strb_t       strb;

    assign win_widen = {cfg_hi_wide, cfg_lo_wide};

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        rom_window_match #(
            .ADDR_W     (ADDR_W),
            .END_LOG2   (WIN_END[w]),
            .NARROW_LOG2(WIN_NARROW[w]),
            .WIDE_LOG2  (WIN_WIDE[w])
        ) u_match (
            .addr (req_addr),
            .widen(win_widen[w]),
            .hit  (win_hit[w])
        );
    end

    assign any_hit = |win_hit;

    rom_cycle_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .hit      (any_hit),
        .wr_en    (cfg_wr_en),
        .bus_ack  (bus_ack),
        .strb     (strb)
    );

    rom_width_sel u_width (
        .clk    (clk),
        .rst_n  (rst_n),
        .strap  (width_strap),
        .ovr_en (cfg_width_ovr),
        .ovr_w16(cfg_width16),
        .is16   (rom_is16)
    );

    assign claim    = strb.claim;
    assign rom_cs_n = strb.cs_n;
    assign memr_n   = strb.memr_n;
    assign memw_n   = strb.memw_n;
    assign wr_n     = strb.wr_n;
endmodule

// File: tb/sim_rom_cs_decoder.sv
module sim_rom_cs_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        bus_ack = 1'b0;
    logic        width_strap = 1'b0;
    logic        cfg_lo_wide = 1'b0, cfg_hi_wide = 1'b0, cfg_wr_en = 1'b0;
    logic        cfg_width_ovr = 1'b0, cfg_width16 = 1'b0;
    logic        claim, rom_cs_n, memr_n, memw_n, wr_n, rom_is16;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_cs_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .bus_ack(bus_ack), .width_strap(width_strap),
        .cfg_lo_wide(cfg_lo_wide), .cfg_hi_wide(cfg_hi_wide), .cfg_wr_en(cfg_wr_en),
        .cfg_width_ovr(cfg_width_ovr), .cfg_width16(cfg_width16),
        .claim(claim), .rom_cs_n(rom_cs_n), .memr_n(memr_n), .memw_n(memw_n),
        .wr_n(wr_n), .rom_is16(rom_is16)
    );

    // {claim, cs_n, memr_n, memw_n, wr_n}
    localparam logic [4:0] P_IDLE  = 5'b0_1111;
    localparam logic [4:0] P_READ  = 5'b1_0011;
    localparam logic [4:0] P_WRITE = 5'b1_0100;
    localparam logic [4:0] P_MUTED = 5'b1_1100;

    function automatic logic [4:0] outs();
        return {claim, rom_cs_n, memr_n, memw_n, wr_n};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        width_strap = strap;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(outs() == P_IDLE, "R13 during reset", 32'(outs()), 32'(P_IDLE));
        rst_n = 1'b1;
        @(negedge clk);
        check(outs() == P_IDLE, "R13 after reset", 32'(outs()), 32'(P_IDLE));
    endtask

    // One access: request for a single cycle, check pattern, hold, ack, check release.
    task automatic access(input logic [31:0] a, input logic wr, input logic [4:0] exp,
                          input string req);
        req_addr = a; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(outs() == exp, req, 32'(outs()), 32'(exp));
        if (exp != P_IDLE) begin
            repeat (2) @(negedge clk);
            check(outs() == exp, "R9 held until ack", 32'(outs()), 32'(exp));
            bus_ack = 1'b1;
            @(negedge clk);
            bus_ack = 1'b0;
            check(outs() == P_IDLE, "R9 release together", 32'(outs()), 32'(P_IDLE));
        end
        @(negedge clk);
    endtask

    task automatic t_low_window();
        cfg_lo_wide = 1'b0;
        access(32'h000F_0000, 1'b0, P_READ, "R1 low start");
        access(32'h000F_FFFF, 1'b0, P_READ, "R1 low end");
        access(32'h000E_FFFF, 1'b0, P_IDLE, "R1 below low");
        access(32'h0010_0000, 1'b0, P_IDLE, "R1 above low");
        access(32'h000E_0000, 1'b0, P_IDLE, "R1 wide start off");
    endtask

    task automatic t_high_window();
        cfg_hi_wide = 1'b0;
        access(32'hFFFC_0000, 1'b0, P_READ, "R2 high start");
        access(32'hFFFF_FFFF, 1'b0, P_READ, "R2 high end");
        access(32'hFFFB_FFFF, 1'b0, P_IDLE, "R2 below high");
        access(32'hFF00_0000, 1'b0, P_IDLE, "R2 wide start off");
    endtask

    task automatic t_widened();
        cfg_lo_wide = 1'b1; cfg_hi_wide = 1'b1;
        access(32'h000E_0000, 1'b0, P_READ, "R3 wide low start");
        access(32'h000F_FFFF, 1'b0, P_READ, "R3 wide low end");
        access(32'h000D_FFFF, 1'b0, P_IDLE, "R3 below wide low");
        access(32'h0010_0000, 1'b0, P_IDLE, "R3 above wide low");
        access(32'hFF00_0000, 1'b0, P_READ, "R4 wide high start");
        access(32'hFFFF_FFFF, 1'b0, P_READ, "R4 wide high end");
        access(32'hFEFF_FFFF, 1'b0, P_IDLE, "R4 below wide high");
        cfg_lo_wide = 1'b0; cfg_hi_wide = 1'b0;
    endtask

    task automatic t_writes();
        cfg_wr_en = 1'b0;
        access(32'h000F_1234, 1'b1, P_MUTED, "R6 write muted");
        access(32'hFFFC_0000, 1'b1, P_MUTED, "R6 write muted high");
        cfg_wr_en = 1'b1;
        access(32'hFFFF_FFFE, 1'b1, P_WRITE, "R7 flash write");
        access(32'h000F_0000, 1'b0, P_READ, "R5 read with wr_en");
        access(32'h1234_5678, 1'b1, P_IDLE, "R8 miss write");
        cfg_wr_en = 1'b0;
        access(32'h0000_0000, 1'b0, P_IDLE, "R8 miss zero");
    endtask

    task automatic t_busy_ignore();
        cfg_wr_en = 1'b1;
        req_addr = 32'h000F_8000; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        check(outs() == P_READ, "R5 read start", 32'(outs()), 32'(P_READ));
        req_addr = 32'hFFFF_0000; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(outs() == P_READ, "R10 busy request ignored", 32'(outs()), 32'(P_READ));
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check(outs() == P_IDLE, "R9 release after busy", 32'(outs()), 32'(P_IDLE));
        repeat (2) @(negedge clk);
        check(outs() == P_IDLE, "R10 no late cycle", 32'(outs()), 32'(P_IDLE));
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check(outs() == P_IDLE, "R9 ack in idle", 32'(outs()), 32'(P_IDLE));
        cfg_wr_en = 1'b0;
    endtask

    task automatic t_width();
        check(rom_is16 == 1'b1, "R11 strap 16 latched", 32'(rom_is16), 32'd1);
        width_strap = 1'b0;
        repeat (2) @(negedge clk);
        check(rom_is16 == 1'b1, "R11 strap change ignored", 32'(rom_is16), 32'd1);
        cfg_width_ovr = 1'b1; cfg_width16 = 1'b0;
        @(negedge clk);
        check(rom_is16 == 1'b0, "R12 override to 8", 32'(rom_is16), 32'd0);
        cfg_width16 = 1'b1;
        @(negedge clk);
        check(rom_is16 == 1'b1, "R12 override to 16", 32'(rom_is16), 32'd1);
        cfg_width_ovr = 1'b0;
        @(negedge clk);
        check(rom_is16 == 1'b1, "R12 override cleared", 32'(rom_is16), 32'd1);
        do_reset(1'b0);
        check(rom_is16 == 1'b0, "R11 strap 8 latched", 32'(rom_is16), 32'd0);
        width_strap = 1'b1;
        repeat (2) @(negedge clk);
        check(rom_is16 == 1'b0, "R11 strap rise ignored", 32'(rom_is16), 32'd0);
    endtask

    initial begin
        do_reset(1'b1);
        t_width();
        t_low_window();
        t_high_window();
        t_widened();
        t_writes();
        t_busy_ignore();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WD_LIMIT; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WD_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule